// File: doc/BRIEF.md
# Clock Ratio Auto-Detector

This block works out how many master clock cycles make up one audio frame when the converter is a slave on its serial port. The frame sync arrives without any fixed phase relationship to the master clock. The block synchronises it and times the spacing between successive rising edges with a saturating counter. It then sorts the spacing into one of six supported ratios: 128, 192, 256, 384, 512 or 768 clocks per frame. A match is allowed up to 32 clocks away from the nominal value. A spacing that fits none of the six selects the fastest-clock setting, 768, and raises a fallback flag.

The reported ratio changes only after two measurements in a row give the same result. This keeps a single disturbed frame or jittery edges from toggling the filter clocking that downstream logic derives from the code. When the mode select says the device masters its own frame clock, detection stops. The valid flag drops and all measurement history is discarded.

Top module: `mclk_ratio_detector`

## Requirements
- R1: A committed measurement within tolerance of a supported ratio reports it on `ratio_code` as 0=128, 1=192, 2=256, 3=384, 4=512, 5=768 clocks per frame, with `ratio_fallback` low.
- R2: The tolerance is inclusive. A period exactly 32 clocks above or below a supported ratio still matches it, and jitter that stays inside the window does not change the result.
- R3: A period more than 32 clocks from every supported ratio classifies as code 5 with `ratio_fallback` high.
- R4: When a period lies within tolerance of two ratios (160 or 224 clocks), the lower code wins.
- R5: The outputs take a new classification only when it equals the previous one, code and fallback both. They change only in the cycle after a synchronised rising frame edge, so alternating classes leave the outputs unchanged.
- R6: The period counter stops at `MAX_COUNT` (default 1023) and never wraps. A gap of 1280 clocks therefore measures as 1023 and falls back to code 5 rather than aliasing to 256.
- R7: While `master_sel` is 1, `ratio_valid` is low from the next cycle on and all measurement history is dropped. After `master_sel` returns to 0, one edge re-arms the counter and two matching measurements are needed again.
- R8: After reset, `ratio_code` is 0 and both flags are low. `ratio_valid` stays low until the first classification is committed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock |
| rst_n | input | 1 | Active-low synchronous reset |
| master_sel | input | 1 | 0 = slave, detection running; 1 = master, detection halted |
| fsync_async | input | 1 | Frame sync, asynchronous to clk |
| ratio_code | output | 3 | Detected clocks-per-frame code |
| ratio_valid | output | 1 | A committed detection is present |
| ratio_fallback | output | 1 | Committed period matched no supported ratio |

## Verification
Two functions can act in the same cycle: the counter saturating, and a frame edge closing the measurement. Frame gaps of 1280 clocks hold the counter at its ceiling for hundreds of cycles before the edge lands. The case is judged by requiring a fallback result, code 5 with the flag high, where a wrapping counter would report 256. A behavioural model in the bench is compared with the outputs on every clock. It also checks that master mode overrides a coinciding frame edge, and that alternating classes never commit.

// File: rtl/crd_pkg.sv
package crd_pkg;

   localparam int N_RATIO = 6;

   typedef logic [2:0] code_t;

   localparam code_t CODE_FALLBACK = 3'd5;

   function automatic int ratio_of(input int idx);
      case (idx)
         0:       return 128;
         1:       return 192;
         2:       return 256;
         3:       return 384;
         4:       return 512;
         default: return 768;
      endcase
   endfunction

endpackage

// File: rtl/crd_sync.sv
module crd_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic din,
   output logic rise
);
   if (STAGES < 2) begin : g_bad_stages
      $error("crd_sync needs at least two stages");
   end

   logic [STAGES:0] sh_q;

   always_ff @(posedge clk) begin
      if (!rst_n) sh_q <= '0;
      else        sh_q <= {sh_q[STAGES-1:0], din};
   end

   assign rise = sh_q[STAGES-1] & ~sh_q[STAGES];

endmodule

// File: rtl/crd_counter.sv
module crd_counter #(
   parameter int CNT_W     = 10,
   parameter int MAX_COUNT = 1023
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             clear,
   input  logic             restart,
   output logic [CNT_W-1:0] count
);
   localparam logic [CNT_W-1:0] LIMIT = CNT_W'(MAX_COUNT);

   if (MAX_COUNT >= (1 << CNT_W)) begin : g_bad_width
      $error("crd_counter limit does not fit its width");
   end

   always_ff @(posedge clk) begin
      if (!rst_n || clear)    count <= '0;
      else if (restart)       count <= CNT_W'(1);
      else if (count != LIMIT) count <= count + CNT_W'(1);
   end

endmodule

// File: rtl/crd_classify.sv
module crd_classify
   import crd_pkg::*;
#(
   parameter int CNT_W = 10,
   parameter int TOL   = 32
) (
   input  logic [CNT_W-1:0] period,
   output code_t            code,
   output logic             fallback
);
   logic [N_RATIO-1:0] hit;
   int                 p;

   assign p = int'({1'b0, period});

   for (genvar i = 0; i < N_RATIO; i++) begin : g_win
      localparam int LO = ratio_of(i) - TOL;
      localparam int HI = ratio_of(i) + TOL;
      assign hit[i] = (p >= LO) && (p <= HI);
   end

   always_comb begin
      code = CODE_FALLBACK;
      for (int i = N_RATIO - 1; i >= 0; i--) begin
         if (hit[i]) code = code_t'(i);
      end
   end

   assign fallback = ~|hit;

endmodule

// File: rtl/mclk_ratio_detector.sv
module mclk_ratio_detector
   import crd_pkg::*;
#(
   parameter int MAX_COUNT   = 1023,
   parameter int TOL         = 32,
   parameter int SYNC_STAGES = 2
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       master_sel,
   input  logic       fsync_async,
   output logic [2:0] ratio_code,
   output logic       ratio_valid,
   output logic       ratio_fallback
);
   localparam int CNT_W = $clog2(MAX_COUNT + 1);

   if (MAX_COUNT <= ratio_of(N_RATIO - 1) + TOL) begin : g_bad_limit
      $error("MAX_COUNT must exceed the widest match window");
   end
   if (TOL < 0) begin : g_bad_tol
      $error("TOL must be non-negative");
   end

   logic             rise_w;
   logic [CNT_W-1:0] cnt_w;
   code_t            cls_code;
   logic             cls_fb;

   logic  armed_q, prev_ok_q, prev_fb_q, fb_q, valid_q;
   code_t prev_code_q, code_q;

   crd_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk  (clk),
      .rst_n(rst_n),
      .din  (fsync_async),
      .rise (rise_w)
   );

   crd_counter #(.CNT_W(CNT_W), .MAX_COUNT(MAX_COUNT)) u_cnt (
      .clk    (clk),
      .rst_n  (rst_n),
      .clear  (master_sel),
      .restart(rise_w),
      .count  (cnt_w)
   );

   crd_classify #(.CNT_W(CNT_W), .TOL(TOL)) u_cls (
      .period  (cnt_w),
      .code    (cls_code),
      .fallback(cls_fb)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         armed_q     <= 1'b0;
         prev_ok_q   <= 1'b0;
         prev_code_q <= '0;
         prev_fb_q   <= 1'b0;
         code_q      <= '0;
         fb_q        <= 1'b0;
         valid_q     <= 1'b0;
      end else if (master_sel) begin
         armed_q   <= 1'b0;
         prev_ok_q <= 1'b0;
         valid_q   <= 1'b0;
      end else if (rise_w) begin
         armed_q <= 1'b1;
         if (armed_q) begin
            prev_code_q <= cls_code;
            prev_fb_q   <= cls_fb;
            prev_ok_q   <= 1'b1;
            if (prev_ok_q && (prev_code_q == cls_code) && (prev_fb_q == cls_fb)) begin
               code_q  <= cls_code;
               fb_q    <= cls_fb;
               valid_q <= 1'b1;
            end
         end
      end
   end

   assign ratio_code     = code_q;
   assign ratio_valid    = valid_q;
   assign ratio_fallback = fb_q;

endmodule

// File: rtl/crd_checker.sv
module crd_checker #(
   parameter int CNT_W     = 10,
   parameter int MAX_COUNT = 1023
) (
   input logic             clk,
   input logic             rst_n,
   input logic             master_sel,
   input logic             rise,
   input logic             armed,
   input logic [CNT_W-1:0] cnt,
   input logic [2:0]       code,
   input logic             valid,
   input logic             fb
);
   assert_code_legal_R1: assert property (@(posedge clk) disable iff (!rst_n)
      code <= 3'd5);

   assert_fallback_code_R3: assert property (@(posedge clk) disable iff (!rst_n)
      fb |-> code == 3'd5);

   assert_change_on_edge_R5: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(code) |-> $past(rise));

   assert_no_wrap_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (cnt == CNT_W'(MAX_COUNT) && !rise && !master_sel) |=> cnt == CNT_W'(MAX_COUNT));

   assert_master_drops_valid_R7: assert property (@(posedge clk) disable iff (!rst_n)
      master_sel |=> !valid);

   assert_valid_needs_edge_R8: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(valid) |-> $past(rise && armed && !master_sel));

endmodule

bind mclk_ratio_detector crd_checker #(.CNT_W(CNT_W), .MAX_COUNT(MAX_COUNT)) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .master_sel(master_sel),
   .rise      (rise_w),
   .armed     (armed_q),
   .cnt       (cnt_w),
   .code      (ratio_code),
   .valid     (ratio_valid),
   .fb        (ratio_fallback)
);

// File: tb/mclk_ratio_detector_tb.sv
module mclk_ratio_detector_tb;
   localparam int CLK_PERIOD = 10;
   localparam int MAXC       = 1023;
   localparam int TOLB       = 32;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       master_sel = 1'b0;
   logic       fs = 1'b0;
   logic [2:0] ratio_code;
   logic       ratio_valid;
   logic       ratio_fallback;

   int vectors = 0;
   int misses  = 0;
   string phase = "R8";

   int ratios[6] = '{128, 192, 256, 384, 512, 768};

   always #(CLK_PERIOD/2) clk = ~clk;

   mclk_ratio_detector u_dut (
      .clk           (clk),
      .rst_n         (rst_n),
      .master_sel    (master_sel),
      .fsync_async   (fs),
      .ratio_code    (ratio_code),
      .ratio_valid   (ratio_valid),
      .ratio_fallback(ratio_fallback)
   );

   // behavioural reference
   int m_s1, m_s2, m_s3, m_cnt;
   int m_armed, m_prev_ok, m_prev_code, m_prev_fb;
   int m_code, m_valid, m_fb;
   int c_code, c_fb;

   task automatic classify(input int per, output int code, output int fbk);
      code = 5;
      fbk  = 1;
      for (int i = 0; i < 6; i++) begin
         if (fbk == 1 && per >= ratios[i] - TOLB && per <= ratios[i] + TOLB) begin
            code = i;
            fbk  = 0;
         end
      end
   endtask

   always @(posedge clk) begin
      if (!rst_n) begin
         m_s1 <= 0; m_s2 <= 0; m_s3 <= 0; m_cnt <= 0;
         m_armed <= 0; m_prev_ok <= 0; m_prev_code <= 0; m_prev_fb <= 0;
         m_code <= 0; m_valid <= 0; m_fb <= 0;
      end else begin
         m_s1 <= int'(fs);
         m_s2 <= m_s1;
         m_s3 <= m_s2;
         if (master_sel) begin
            m_cnt <= 0; m_armed <= 0; m_prev_ok <= 0; m_valid <= 0;
         end else if (m_s2 == 1 && m_s3 == 0) begin
            m_cnt   <= 1;
            m_armed <= 1;
            if (m_armed == 1) begin
               classify(m_cnt, c_code, c_fb);
               m_prev_code <= c_code;
               m_prev_fb   <= c_fb;
               m_prev_ok   <= 1;
               if (m_prev_ok == 1 && c_code == m_prev_code && c_fb == m_prev_fb) begin
                  m_code <= c_code; m_fb <= c_fb; m_valid <= 1;
               end
            end
         end else if (m_cnt < MAXC) begin
            m_cnt <= m_cnt + 1;
         end
      end
   end

   always @(negedge clk) begin
      if (rst_n) begin
         vectors++;
         if (int'(ratio_code) != m_code || int'(ratio_valid) != m_valid ||
             int'(ratio_fallback) != m_fb) begin
            misses++;
            $display("FAIL %s: code/valid/fb = %0d/%0d/%0d expected %0d/%0d/%0d at %0t",
                     phase, ratio_code, ratio_valid, ratio_fallback,
                     m_code, m_valid, m_fb, $time);
         end
      end
   end

   task automatic check_now(input string tag, input int ecode, input int evalid, input int efb);
      vectors++;
      if ((ecode >= 0 && int'(ratio_code) != ecode) || int'(ratio_valid) != evalid ||
          int'(ratio_fallback) != efb) begin
         misses++;
         $display("FAIL %s: code/valid/fb = %0d/%0d/%0d expected %0d/%0d/%0d",
                  tag, ratio_code, ratio_valid, ratio_fallback, ecode, evalid, efb);
      end
   endtask

   task automatic frames(input int per, input int n);
      for (int i = 0; i < n; i++) begin
         fs = 1'b1;
         repeat (per / 2) @(negedge clk);
         fs = 1'b0;
         repeat (per - per / 2) @(negedge clk);
      end
   endtask

   initial begin
      #(CLK_PERIOD * 200000);
      misses++;
      $display("FAIL watchdog: run did not finish, expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
      $finish;
   end

   initial begin
      repeat (4) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      phase = "R8";
      check_now("R8 reset", 0, 0, 0);
      frames(256, 2);
      check_now("R8 one measurement", 0, 0, 0);
      frames(256, 2);
      phase = "R1";
      check_now("R1 256", 2, 1, 0);
      for (int r = 0; r < 6; r++) begin
         frames(ratios[r], 4);
         check_now("R1 ratio sweep", r, 1, 0);
      end
      phase = "R2";
      frames(288, 4);  check_now("R2 256+32", 2, 1, 0);
      frames(352, 4);  check_now("R2 384-32", 3, 1, 0);
      frames(96, 4);   check_now("R2 128-32", 0, 1, 0);
      frames(800, 4);  check_now("R2 768+32", 5, 1, 0);
      for (int k = 0; k < 6; k++) frames((k % 2 == 0) ? 250 : 262, 1);
      check_now("R2 jitter", 2, 1, 0);
      phase = "R3";
      frames(289, 4);  check_now("R3 289", 5, 1, 1);
      frames(128, 4);  check_now("R3 recover", 0, 1, 0);
      frames(95, 4);   check_now("R3 95", 5, 1, 1);
      frames(600, 4);  check_now("R3 600", 5, 1, 1);
      phase = "R4";
      frames(160, 4);  check_now("R4 tie 160", 0, 1, 0);
      frames(224, 4);  check_now("R4 tie 224", 1, 1, 0);
      phase = "R5";
      frames(512, 4);  check_now("R5 setup", 4, 1, 0);
      for (int k = 0; k < 3; k++) begin
         frames(256, 1);
         frames(384, 1);
      end
      check_now("R5 alternating", 4, 1, 0);
      frames(256, 5);
      frames(400, 1);
      frames(256, 1);
      check_now("R5 single odd frame", 2, 1, 0);
      frames(256, 3);
      phase = "R6";
      frames(1280, 4); check_now("R6 saturated", 5, 1, 1);
      frames(256, 4);  check_now("R6 recover", 2, 1, 0);
      phase = "R7";
      master_sel = 1'b1;
      @(negedge clk);
      check_now("R7 master", -1, 0, 0);
      frames(256, 4);
      check_now("R7 master frames", -1, 0, 0);
      master_sel = 1'b0;
      frames(256, 2);
      check_now("R7 rearm", -1, 0, 0);
      frames(256, 2);
      check_now("R7 resumed", 2, 1, 0);
      repeat (8) @(negedge clk);
      $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
      $finish;
   end

endmodule